// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block computes every state change a hart makes when it takes an exception or an interrupt. The core presents the raw trap on one strobed cycle: the cause code, whether it is an interrupt, the faulting address, the current PC and privilege, the current status bits, both delegation masks and both trap-vector registers. An address-translation failure can also be reported through a separate flag. In that case the block derives the fault cause itself from the access kind and from whether translation is enabled.

The controller decides whether the trap is handled at supervisor or at machine level. It produces the new status bits, the cause, the exception-PC and trap-value contents for that level, the handler PC and the new privilege. All of these are registered and appear together for one cycle, qualified by `out_valid`. The core writes the results into its own CSR file. Returning from a trap and choosing among pending interrupts are not part of this block.

Control is a two-state machine:
- `ST_IDLE` means no result is being presented.
- `ST_COMMIT` presents the result of the strobe taken on the previous edge.

The transitions are:
- `GO_COMMIT`: `ST_IDLE` to `ST_COMMIT` on `trap_valid`.
- `STAY_COMMIT`: `ST_COMMIT` to `ST_COMMIT` on a back-to-back `trap_valid`.
- `GO_IDLE`: `ST_COMMIT` to `ST_IDLE` when `trap_valid` is low.
- `HOLD_IDLE`: `ST_IDLE` to `ST_IDLE` when `trap_valid` is low.

Privilege encoding is 0 user, 1 supervisor, 2 hypervisor, 3 machine.

Top module: `trap_entry`

## Requirements
- R1: For an interrupt the delegation bit is taken from `ideleg`. For an exception it is taken from `edeleg`.
- R2: `out_tval` equals `fault_addr` for exception causes 0, 1, 4, 5, 6, 7, 12, 13 and 15 (misaligned, access-fault and page-fault on fetch, load and store). For every other cause, and for every interrupt, `out_tval` is zero.
- R3: An exception with cause 8 (environment call) is reported as cause 8 plus the current privilege: 8 for user, 9 for supervisor, 10 for hypervisor, 11 for machine. This remapped code is the one used for delegation.
- R4: The trap goes to supervisor (`out_to_s`=1, `out_priv`=1) when the current privilege is 0 or 1 and the selected delegation bit for the cause is set. Otherwise it goes to machine (`out_to_s`=0, `out_priv`=3).
- R5: On a supervisor trap, `out_spie` takes `st_sie`, `out_spp` takes bit 0 of the current privilege, and `out_sie` is cleared. On a machine trap, `out_mpie` takes `st_mie`, `out_mpp` takes the current privilege, and `out_mie` is cleared. The fields of the other level pass through unchanged.
- R6: Bits `CAUSE_W-1:0` of `out_cause` hold the final cause code. Bit XLEN-1 of `out_cause` is 1 for an interrupt and 0 for an exception, and all other bits are zero. `out_epc` equals `cur_pc`.
- R7: `out_pc` is the selected level's trap vector with bits 1:0 cleared. When the trap is an interrupt and the vector's bits 1:0 equal 01, four times the cause is added.
- R8: With `xlate_fail`=1 the trap is an exception whatever `trap_async` holds, and `trap_cause` is replaced. `xlate_acc` encodes the access kind: 0 fetch, 1 load, any other value store. With `xlate_on`=1 the cause is 12, 13 or 15. With `xlate_on`=0 it is 1, 5 or 7.
- R9: Results appear exactly one cycle after the `trap_valid` cycle, with `out_valid`=1 for that single cycle. Back-to-back strobes give back-to-back results. After reset `out_valid` is 0 and all outputs are zero.
- R10: A cause code of XLEN or more is never delegated and always goes to machine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_valid | input | 1 | Trap strobe, one cycle per trap |
| trap_async | input | 1 | 1 for an interrupt, 0 for an exception |
| trap_cause | input | CAUSE_W | Raw cause code |
| xlate_fail | input | 1 | Trap is an address-translation failure |
| xlate_acc | input | 2 | Access kind of the failed translation |
| xlate_on | input | 1 | Translation enabled (not bare) |
| fault_addr | input | XLEN | Faulting address |
| cur_pc | input | XLEN | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege |
| ideleg | input | XLEN | Interrupt delegation mask |
| edeleg | input | XLEN | Exception delegation mask |
| st_sie | input | 1 | Supervisor interrupt enable |
| st_spie | input | 1 | Supervisor previous interrupt enable |
| st_spp | input | 1 | Supervisor previous privilege |
| st_mie | input | 1 | Machine interrupt enable |
| st_mpie | input | 1 | Machine previous interrupt enable |
| st_mpp | input | 2 | Machine previous privilege |
| mtvec | input | XLEN | Machine trap vector |
| stvec | input | XLEN | Supervisor trap vector |
| out_valid | output | 1 | Result valid for this cycle |
| out_to_s | output | 1 | 1 supervisor target, 0 machine target |
| out_priv | output | 2 | New privilege |
| out_sie | output | 1 | New supervisor interrupt enable |
| out_spie | output | 1 | New supervisor previous interrupt enable |
| out_spp | output | 1 | New supervisor previous privilege |
| out_mie | output | 1 | New machine interrupt enable |
| out_mpie | output | 1 | New machine previous interrupt enable |
| out_mpp | output | 2 | New machine previous privilege |
| out_cause | output | XLEN | Value for the target level's cause register |
| out_epc | output | XLEN | Value for the target level's exception PC |
| out_tval | output | XLEN | Value for the target level's trap-value register |
| out_pc | output | XLEN | Handler PC |

## Verification
The traps applied alternate between interrupts and exceptions whose delegation bit is set in only one of the two masks. This shows whether the correct mask is consulted. The same cause is taken from user, supervisor, hypervisor and machine privilege, which separates the privilege gate from the mask test. Every privilege is also used for environment calls, so a missing remap shows up as a wrong code or a wrong target.

Translation failures cover all access kinds with translation both enabled and bare, and some carry a raised interrupt flag. Exceptions that should and should not capture the address are compared on `out_tval`. Vectored and direct trap vectors are tried with interrupts and with exceptions. A cause above the register width is also applied, and back-to-back strobes show that one result is produced per strobe.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int unsigned CODE_ECALL   = 8;
    localparam int unsigned CODE_IPF     = 12;
    localparam int unsigned CODE_LPF     = 13;
    localparam int unsigned CODE_SPF     = 15;
    localparam int unsigned CODE_IAF     = 1;
    localparam int unsigned CODE_LAF     = 5;
    localparam int unsigned CODE_SAF     = 7;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } fsm_t;

    typedef struct packed {
        logic       sie;
        logic       spie;
        logic       spp;
        logic       mie;
        logic       mpie;
        logic [1:0] mpp;
    } stat_t;
endpackage

// File: rtl/trap_cause_fix.sv
module trap_cause_fix
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input  logic               raw_async,
    input  logic [CAUSE_W-1:0] raw_cause,
    input  logic               xf,
    input  logic [1:0]         xacc,
    input  logic               xon,
    input  logic [1:0]         priv,
    input  logic [XLEN-1:0]    addr,
    output logic               eff_async,
    output logic [CAUSE_W-1:0] eff_cause,
    output logic [XLEN-1:0]    tval
);
    logic [CAUSE_W-1:0] xcode;
    logic [CAUSE_W-1:0] pre;
    logic               addr_kind;

    // translation failure always reports as a synchronous fault
    always_comb begin
        unique case (xacc)
            2'd0:    xcode = xon ? CAUSE_W'(CODE_IPF) : CAUSE_W'(CODE_IAF);
            2'd1:    xcode = xon ? CAUSE_W'(CODE_LPF) : CAUSE_W'(CODE_LAF);
            default: xcode = xon ? CAUSE_W'(CODE_SPF) : CAUSE_W'(CODE_SAF);
        endcase
    end

    assign eff_async = raw_async & ~xf;
    assign pre       = xf ? xcode : raw_cause;

    always_comb begin
        eff_cause = pre;
        if (!eff_async && pre == CAUSE_W'(CODE_ECALL))
            eff_cause = CAUSE_W'(CODE_ECALL) + CAUSE_W'(priv);
    end

    always_comb begin
        unique case (int'(eff_cause))
            0, 1, 4, 5, 6, 7, 12, 13, 15: addr_kind = 1'b1;
            default:                      addr_kind = 1'b0;
        endcase
    end

    assign tval = (!eff_async && addr_kind) ? addr : '0;
endmodule

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input  logic               is_async,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [1:0]         priv,
    input  logic [XLEN-1:0]    ideleg,
    input  logic [XLEN-1:0]    edeleg,
    output logic               to_s
);
    localparam int IDX_W = $clog2(XLEN);

    logic [XLEN-1:0] mask;
    logic            in_range;
    logic            bit_set;

    assign mask     = is_async ? ideleg : edeleg;
    assign in_range = int'(cause) < XLEN;
    assign bit_set  = in_range && mask[cause[IDX_W-1:0]];
    assign to_s     = (priv <= PRIV_S) && bit_set;
endmodule

// File: rtl/trap_vec.sv
module trap_vec #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input  logic               to_s,
    input  logic               is_async,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]    mtvec,
    input  logic [XLEN-1:0]    stvec,
    output logic [XLEN-1:0]    next_pc
);
    logic [XLEN-1:0] tv;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offs;

    assign tv   = to_s ? stvec : mtvec;
    assign base = {tv[XLEN-1:2], 2'b00};
    assign offs = (is_async && tv[1:0] == 2'b01) ? XLEN'({cause, 2'b00}) : '0;
    assign next_pc = base + offs;
endmodule

// File: rtl/trap_entry.sv
module trap_entry
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid,
    input  logic               trap_async,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic               xlate_fail,
    input  logic [1:0]         xlate_acc,
    input  logic               xlate_on,
    input  logic [XLEN-1:0]    fault_addr,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [1:0]         cur_priv,
    input  logic [XLEN-1:0]    ideleg,
    input  logic [XLEN-1:0]    edeleg,
    input  logic               st_sie,
    input  logic               st_spie,
    input  logic               st_spp,
    input  logic               st_mie,
    input  logic               st_mpie,
    input  logic [1:0]         st_mpp,
    input  logic [XLEN-1:0]    mtvec,
    input  logic [XLEN-1:0]    stvec,
    output logic               out_valid,
    output logic               out_to_s,
    output logic [1:0]         out_priv,
    output logic               out_sie,
    output logic               out_spie,
    output logic               out_spp,
    output logic               out_mie,
    output logic               out_mpie,
    output logic [1:0]         out_mpp,
    output logic [XLEN-1:0]    out_cause,
    output logic [XLEN-1:0]    out_epc,
    output logic [XLEN-1:0]    out_tval,
    output logic [XLEN-1:0]    out_pc
);
    localparam int PAD_W = XLEN - 1 - CAUSE_W;

    fsm_t               state, state_nx;
    logic               e_async;
    logic [CAUSE_W-1:0] e_cause;
    logic [XLEN-1:0]    e_tval;
    logic               e_to_s;
    logic [XLEN-1:0]    e_pc;
    stat_t              st_in, st_new, st_q;

    trap_cause_fix #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_fix (
        .raw_async (trap_async),
        .raw_cause (trap_cause),
        .xf        (xlate_fail),
        .xacc      (xlate_acc),
        .xon       (xlate_on),
        .priv      (cur_priv),
        .addr      (fault_addr),
        .eff_async (e_async),
        .eff_cause (e_cause),
        .tval      (e_tval)
    );

    trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
        .is_async (e_async),
        .cause    (e_cause),
        .priv     (cur_priv),
        .ideleg   (ideleg),
        .edeleg   (edeleg),
        .to_s     (e_to_s)
    );

    trap_vec #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
        .to_s     (e_to_s),
        .is_async (e_async),
        .cause    (e_cause),
        .mtvec    (mtvec),
        .stvec    (stvec),
        .next_pc  (e_pc)
    );

    assign st_in = '{sie: st_sie, spie: st_spie, spp: st_spp,
                     mie: st_mie, mpie: st_mpie, mpp: st_mpp};

    always_comb begin
        st_new = st_in;
        if (e_to_s) begin
            st_new.spie = st_in.sie;
            st_new.spp  = cur_priv[0];
            st_new.sie  = 1'b0;
        end else begin
            st_new.mpie = st_in.mie;
            st_new.mpp  = cur_priv;
            st_new.mie  = 1'b0;
        end
    end

    // next-state logic: GO_COMMIT, STAY_COMMIT, GO_IDLE, HOLD_IDLE
    always_comb begin
        unique case (state)
            ST_IDLE:   state_nx = trap_valid ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_nx = trap_valid ? ST_COMMIT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_to_s  <= 1'b0;
            out_priv  <= 2'd0;
            st_q      <= '0;
            out_cause <= '0;
            out_epc   <= '0;
            out_tval  <= '0;
            out_pc    <= '0;
        end else if (trap_valid) begin
            out_to_s  <= e_to_s;
            out_priv  <= e_to_s ? PRIV_S : PRIV_M;
            st_q      <= st_new;
            out_cause <= {e_async, {PAD_W{1'b0}}, e_cause};
            out_epc   <= cur_pc;
            out_tval  <= e_tval;
            out_pc    <= e_pc;
        end
    end

    assign out_valid = (state == ST_COMMIT);
    assign out_sie   = st_q.sie;
    assign out_spie  = st_q.spie;
    assign out_spp   = st_q.spp;
    assign out_mie   = st_q.mie;
    assign out_mpie  = st_q.mpie;
    assign out_mpp   = st_q.mpp;

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> out_valid) else $error("one-cycle commit"); // R9
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |=> !out_valid) else $error("spurious valid"); // R9
    AST_HIGH_PRIV_M: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && cur_priv > PRIV_S |=> !out_to_s && out_priv == PRIV_M)
        else $error("high priv delegated"); // R4
    AST_WIDE_CAUSE_M: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && !xlate_fail && int'(trap_cause) >= XLEN |=> !out_to_s)
        else $error("wide cause delegated"); // R10
    AST_IE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> (out_to_s ? !out_sie : !out_mie))
        else $error("interrupt enable kept"); // R5
    AST_CAUSE_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> out_cause[XLEN-1] == $past(trap_async && !xlate_fail))
        else $error("cause msb"); // R6
    AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && (!trap_async || xlate_fail) |=> out_pc[1:0] == 2'b00)
        else $error("sync pc unaligned"); // R7
    AST_ECALL_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && !trap_async && !xlate_fail && trap_cause == CAUSE_W'(8)
        |=> out_cause[CAUSE_W-1:0] == CAUSE_W'(8) + CAUSE_W'($past(cur_priv)))
        else $error("ecall remap"); // R3
    AST_XLATE_TVAL: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && xlate_fail |=> out_tval == $past(fault_addr))
        else $error("xlate tval"); // R8
endmodule

// File: tb/trap_entry_bench.sv
module trap_entry_bench;
    localparam int XLEN = 32;
    localparam int CW   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic            trap_valid = 0, trap_async = 0, xlate_fail = 0, xlate_on = 0;
    logic [CW-1:0]   trap_cause = '0;
    logic [1:0]      xlate_acc = '0, cur_priv = '0, st_mpp = '0;
    logic [XLEN-1:0] fault_addr = '0, cur_pc = '0, ideleg = '0, edeleg = '0;
    logic [XLEN-1:0] mtvec = '0, stvec = '0;
    logic            st_sie = 0, st_spie = 0, st_spp = 0, st_mie = 0, st_mpie = 0;

    logic            out_valid, out_to_s, out_sie, out_spie, out_spp, out_mie, out_mpie;
    logic [1:0]      out_priv, out_mpp;
    logic [XLEN-1:0] out_cause, out_epc, out_tval, out_pc;

    trap_entry #(.XLEN(XLEN), .CAUSE_W(CW)) u_trap_entry (.*);

    typedef struct {
        logic            to_s;
        logic [1:0]      priv;
        logic [6:0]      st;
        logic [XLEN-1:0] cause, epc, tval, pc;
        string           tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    task automatic chk(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(string tag);
        exp_t e;
        logic as;
        int c;
        logic [XLEN-1:0] dm, tv;
        as = trap_async && !xlate_fail;
        c  = int'(trap_cause);
        if (xlate_fail) begin
            if (xlate_acc == 0)      c = xlate_on ? 12 : 1;
            else if (xlate_acc == 1) c = xlate_on ? 13 : 5;
            else                     c = xlate_on ? 15 : 7;
        end
        if (!as && c == 8) c = 8 + int'(cur_priv);
        e.tval = '0;
        if (!as && (c inside {0, 1, 4, 5, 6, 7, 12, 13, 15})) e.tval = fault_addr;
        dm = as ? ideleg : edeleg;
        e.to_s = (cur_priv <= 1) && (c < XLEN) && dm[c % XLEN];
        e.priv = e.to_s ? 2'd1 : 2'd3;
        e.cause = XLEN'(c);
        e.cause[XLEN-1] = as;
        e.epc = cur_pc;
        tv = e.to_s ? stvec : mtvec;
        e.pc = (tv & ~32'h3) + ((as && tv[1:0] == 2'b01) ? XLEN'(4 * c) : '0);
        if (e.to_s) e.st = {1'b0, st_sie, cur_priv[0], st_mie, st_mpie, st_mpp};
        else        e.st = {st_sie, st_spie, st_spp, 1'b0, st_mie, cur_priv};
        e.tag = tag;
        return e;
    endfunction

    task automatic send(string tag, logic as, logic [CW-1:0] c, logic [1:0] pv,
                        logic xf, logic [1:0] xa, logic xo);
        @(negedge clk);
        trap_async = as; trap_cause = c; cur_priv = pv;
        xlate_fail = xf; xlate_acc = xa; xlate_on = xo;
        fault_addr = $urandom; cur_pc = $urandom;
        {st_sie, st_spie, st_spp, st_mie, st_mpie, st_mpp} = 7'($urandom);
        trap_valid = 1'b1;
        q.push_back(model(tag));
    endtask

    task automatic idle();
        @(negedge clk);
        trap_valid = 1'b0;
    endtask

    // monitor: compare each result against the scoreboard
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("R9", "valid", XLEN'(out_valid), XLEN'(q.size() > 0));
            if (out_valid && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "to_s", XLEN'(out_to_s), XLEN'(e.to_s));
                chk(e.tag, "priv", XLEN'(out_priv), XLEN'(e.priv));
                chk(e.tag, "status", XLEN'({out_sie, out_spie, out_spp, out_mie, out_mpie, out_mpp}), XLEN'(e.st));
                chk(e.tag, "cause", out_cause, e.cause);
                chk(e.tag, "epc", out_epc, e.epc);
                chk(e.tag, "tval", out_tval, e.tval);
                chk(e.tag, "pc", out_pc, e.pc);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        mtvec = 32'h0000_1001;
        stvec = 32'h0000_2001;
        repeat (3) @(negedge clk);
        chk("R9", "reset valid", XLEN'(out_valid), '0);
        chk("R9", "reset pc", out_pc, '0);
        chk("R9", "reset cause", out_cause, '0);
        rst_n = 1'b1;
        idle();

        // R1 R4 exception mask vs interrupt mask
        edeleg = 32'h0000_2000; ideleg = 32'h0000_0020;
        send("R1_sync_pf_to_s", 0, 6'd13, 2'd0, 0, 0, 0); idle();
        send("R1_async_to_s", 1, 6'd5, 2'd1, 0, 0, 0); idle();
        edeleg = 32'h0000_0020; ideleg = 32'h0000_2000;
        send("R1_async_to_m", 1, 6'd5, 2'd1, 0, 0, 0); idle();
        send("R1_sync_to_s", 0, 6'd5, 2'd0, 0, 0, 0); idle();
        edeleg = 32'hFFFF_FFFF; ideleg = 32'hFFFF_FFFF;
        send("R4_from_m", 0, 6'd2, 2'd3, 0, 0, 0); idle();
        send("R4_from_h", 1, 6'd7, 2'd2, 0, 0, 0); idle();
        // R3 environment calls
        edeleg = 32'h0000_0200;
        send("R3_ecall_u", 0, 6'd8, 2'd0, 0, 0, 0); idle();
        send("R3_ecall_s", 0, 6'd8, 2'd1, 0, 0, 0); idle();
        send("R3_ecall_h", 0, 6'd8, 2'd2, 0, 0, 0); idle();
        send("R3_ecall_m", 0, 6'd8, 2'd3, 0, 0, 0); idle();
        // R8 translation failures
        edeleg = 32'h0000_0000;
        send("R8_fetch_on", 0, 6'd3, 2'd0, 1, 2'd0, 1); idle();
        send("R8_fetch_off", 1, 6'd3, 2'd0, 1, 2'd0, 0); idle();
        send("R8_load_on", 0, 6'd3, 2'd1, 1, 2'd1, 1); idle();
        send("R8_load_off", 0, 6'd3, 2'd1, 1, 2'd1, 0); idle();
        send("R8_store_on", 1, 6'd3, 2'd1, 1, 2'd2, 1); idle();
        send("R8_store_off", 0, 6'd3, 2'd0, 1, 2'd3, 0); idle();
        // R2 trap value selection
        send("R2_illegal", 0, 6'd2, 2'd0, 0, 0, 0); idle();
        send("R2_misalign", 0, 6'd4, 2'd0, 0, 0, 0); idle();
        send("R2_irq_zero", 1, 6'd13, 2'd0, 0, 0, 0); idle();
        // R10 wide cause
        edeleg = 32'hFFFF_FFFF; ideleg = 32'hFFFF_FFFF;
        send("R10_wide_sync", 0, 6'd40, 2'd0, 0, 0, 0); idle();
        send("R10_wide_async", 1, 6'd33, 2'd1, 0, 0, 0); idle();
        // R7 direct vector and vectored interrupts at both levels
        mtvec = 32'h0000_3000; stvec = 32'h0000_4002;
        send("R7_direct_m", 1, 6'd11, 2'd3, 0, 0, 0); idle();
        send("R7_direct_s", 1, 6'd9, 2'd0, 0, 0, 0); idle();
        mtvec = 32'h0000_5001;
        send("R7_vec_m", 1, 6'd11, 2'd3, 0, 0, 0); idle();
        // R5 R6 R9 back-to-back mixed
        send("R9_b2b_a", 0, 6'd12, 2'd1, 0, 0, 0);
        send("R9_b2b_b", 1, 6'd1, 2'd0, 0, 0, 0);
        send("R5_b2b_c", 0, 6'd15, 2'd2, 0, 0, 0);
        idle(); idle();
        chk("R9", "queue drained", XLEN'(q.size()), '0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule